// File: doc/BRIEF.md
# Shifter Operand Generation Unit

This block forms the second operand of a 32-bit data-processing datapath and the scaled address offset of word and byte load/store instructions. It looks at the instruction word, the value of the register that is to be shifted, the low byte of a second register that may hold a shift amount, and the current carry flag. It returns the operand, the shifter carry-out and a flag that asks for one extra internal cycle. Register-file reads and the ALU sit outside the block.

Three operand forms are handled. The first is an 8-bit immediate rotated right by an even amount. The second is a register shifted by a 5-bit constant from the instruction. The third is a register shifted by an amount held in another register. A mode input picks the data-processing view or the load/store offset view. The offset view adds a plain 12-bit offset form and reads a zero-length right shift as a 32-bit shift. A parameter places a register on all outputs. That register is present by default.

Top module: `operand_shifter`

## Requirements
- R1: With `OUT_REG`=1, all outputs are 0 while `rst_ni` is low, and each result appears at the outputs one clock after its inputs are sampled.
- R2: With `mode_i`=0 and instruction bit 25 = 1, the operand is bits 7:0 rotated right by twice bits 11:8. The carry-out is result bit 31 when that field is nonzero and `carry_i` when it is zero.
- R3: With bit 25 = 0 and bit 4 = 0, the register value is shifted by the amount in bits 11:7. Bits 6:5 select the kind: 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right. The carry-out is the last bit shifted out.
- R4: An immediate left shift of amount 0 leaves the register value unchanged and passes `carry_i` to the carry-out, in either mode.
- R5: An immediate rotate of amount 0 rotates right by one through carry: `carry_i` enters bit 31 and the old bit 0 becomes the carry-out, in either mode.
- R6: With `mode_i`=0, an immediate right logical or right arithmetic shift of amount 0 leaves the value unchanged and passes `carry_i`.
- R7: With `mode_i`=1, an immediate right logical shift of amount 0 gives 0, and an immediate right arithmetic shift of amount 0 gives 32 copies of bit 31. In both cases the carry-out is the old bit 31.
- R8: With `mode_i`=1 and bit 25 = 0, the operand is bits 11:0 zero-extended and the carry-out is `carry_i`.
- R9: With `mode_i`=1 and bit 25 = 1, the register is shifted by the immediate amount as in R3 to R5 and R7, whatever bit 4 holds, and no extra cycle is flagged.
- R10: With `mode_i`=0, bit 25 = 0 and bit 4 = 1, the shift amount is `rs_low_i`. `extra_cycle_o` is 1 exactly in this form.
- R11: A register-held amount of 0 leaves the value unchanged and passes `carry_i`, for all four kinds.
- R12: For register-held amounts of 32 or more:
  - left and right logical shifts give 0, with carry bit 0 or bit 31 respectively at exactly 32 and carry 0 above 32;
  - right arithmetic fills every bit with the sign and carries the sign;
  - rotate uses the amount modulo 32, and a nonzero multiple of 32 leaves the value unchanged with carry bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_i | input | 32 | Instruction word |
| rm_val_i | input | 32 | Value of the register to be shifted |
| rs_low_i | input | 8 | Low byte of the amount register |
| carry_i | input | 1 | Incoming carry flag |
| mode_i | input | 1 | 0 = data-processing operand, 1 = load/store offset |
| op_o | output | 32 | Shifted operand or offset |
| carry_o | output | 1 | Shifter carry-out |
| extra_cycle_o | output | 1 | One extra internal cycle needed |

## Verification
The block holds no state apart from the output register, so a wrong decode or a wrong shift-network path shows up at `op_o` or `carry_o` in the cycle after the offending inputs. A reference model in the bench predicts every cycle and compares against the outputs. Zero-amount encodings, the amounts 32, 33 and 255, and rotations by whole multiples of 32 all go through narrow paths that random words seldom reach, so each is driven on purpose. Thousands of random words then cover the kind and form combinations.

// File: rtl/shop_pkg.sv
`timescale 1ns/1ps
package shop_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;

  typedef enum logic [1:0] {
    FORM_ROT_IMM,
    FORM_IMM_SHIFT,
    FORM_REG_SHIFT,
    FORM_RAW_OFFSET
  } form_e;

  typedef struct packed {
    form_e       form;
    shift_kind_e kind;
    logic [7:0]  amount;
    logic        rrx;
  } shift_ctl_t;
endpackage

// File: rtl/shop_rotr.sv
`timescale 1ns/1ps
module shop_rotr #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  d_i,
  input  logic [SW-1:0] amt_i,
  output logic [W-1:0]  q_o
);
  logic [W-1:0] stage [SW+1];

  assign stage[0] = d_i;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int D = 1 << k;
    assign stage[k+1] = amt_i[k] ? {stage[k][D-1:0], stage[k][W-1:D]} : stage[k];
  end

  assign q_o = stage[SW];
endmodule

// File: rtl/shop_decode.sv
`timescale 1ns/1ps
module shop_decode
  import shop_pkg::*;
#(
  parameter int AMT_W = 8
) (
  input  logic [31:0]      instr_i,
  input  logic [AMT_W-1:0] rs_low_i,
  input  logic             mode_i,
  output shift_ctl_t       ctl_o,
  output logic             extra_cycle_o
);
  logic [4:0]  imm_amt;
  shift_kind_e kind;

  assign imm_amt = instr_i[11:7];
  assign kind    = shift_kind_e'(instr_i[6:5]);

  always_comb begin
    ctl_o.form    = FORM_IMM_SHIFT;
    ctl_o.kind    = kind;
    ctl_o.amount  = 8'(imm_amt);
    ctl_o.rrx     = 1'b0;
    extra_cycle_o = 1'b0;
    if (mode_i) begin
      if (!instr_i[25]) begin
        ctl_o.form = FORM_RAW_OFFSET;
      end else if (imm_amt == 5'd0) begin
        // zero amount: rotate -> through-carry, right shifts -> full width
        unique case (kind)
          SH_ROR:         ctl_o.rrx    = 1'b1;
          SH_LSR, SH_ASR: ctl_o.amount = 8'd32;
          default:        ctl_o.amount = 8'd0;
        endcase
      end
    end else if (instr_i[25]) begin
      ctl_o.form = FORM_ROT_IMM;
    end else if (instr_i[4]) begin
      ctl_o.form    = FORM_REG_SHIFT;
      ctl_o.amount  = 8'(rs_low_i);
      extra_cycle_o = 1'b1;
    end else if (imm_amt == 5'd0 && kind == SH_ROR) begin
      ctl_o.rrx = 1'b1;
    end
  end
endmodule

// File: rtl/shop_barrel.sv
`timescale 1ns/1ps
module shop_barrel
  import shop_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  logic [W-1:0]     val_i,
  input  shift_kind_e      kind_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             rrx_i,
  input  logic             carry_i,
  output logic [W-1:0]     res_o,
  output logic             carry_o
);
  localparam int SW = $clog2(W);

  logic [SW-1:0] s, rot_amt, rsh_cidx;
  logic [W-1:0]  rotated, lmask, rmask;
  logic          wide, exact_w, zero, sign;

  assign s        = amt_i[SW-1:0];
  assign wide     = amt_i >= AMT_W'(W);
  assign exact_w  = amt_i == AMT_W'(W);
  assign zero     = amt_i == '0;
  assign sign     = val_i[W-1];
  // left shift = rotate right by W - s; same value indexes the left carry
  assign rot_amt  = (kind_i == SH_LSL) ? (~s + 1'b1) : s;
  assign rsh_cidx = s - 1'b1;
  assign lmask    = {W{1'b1}} << s;
  assign rmask    = {W{1'b1}} >> s;

  shop_rotr #(.W(W), .SW(SW)) u_rot (
    .d_i  (val_i),
    .amt_i(rot_amt),
    .q_o  (rotated)
  );

  always_comb begin
    res_o   = val_i;
    carry_o = carry_i;
    if (rrx_i) begin
      res_o   = {carry_i, val_i[W-1:1]};
      carry_o = val_i[0];
    end else if (!zero) begin
      unique case (kind_i)
        SH_LSL: begin
          if (wide) begin
            res_o   = '0;
            carry_o = exact_w & val_i[0];
          end else begin
            res_o   = rotated & lmask;
            carry_o = val_i[rot_amt];
          end
        end
        SH_LSR: begin
          if (wide) begin
            res_o   = '0;
            carry_o = exact_w & sign;
          end else begin
            res_o   = rotated & rmask;
            carry_o = val_i[rsh_cidx];
          end
        end
        SH_ASR: begin
          if (wide) begin
            res_o   = {W{sign}};
            carry_o = sign;
          end else begin
            res_o   = (rotated & rmask) | ({W{sign}} & ~rmask);
            carry_o = val_i[rsh_cidx];
          end
        end
        default: begin
          // modulo rotate; s==0 wraps the carry index to the top bit
          res_o   = rotated;
          carry_o = val_i[rsh_cidx];
        end
      endcase
    end
  end
endmodule

// File: rtl/operand_shifter.sv
`timescale 1ns/1ps
module operand_shifter
  import shop_pkg::*;
#(
  parameter int  W       = 32,
  parameter int  AMT_W   = 8,
  parameter int  IMM_W   = 8,
  parameter int  OFF_W   = 12,
  parameter bit  OUT_REG = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [31:0]      instr_i,
  input  logic [W-1:0]     rm_val_i,
  input  logic [AMT_W-1:0] rs_low_i,
  input  logic             carry_i,
  input  logic             mode_i,
  output logic [W-1:0]     op_o,
  output logic             carry_o,
  output logic             extra_cycle_o
);
  localparam int SW = $clog2(W);

  shift_ctl_t   ctl;
  logic         extra_d;
  logic [W-1:0] sh_res, imm_res, op_d;
  logic         sh_carry, imm_carry, carry_d;
  logic [3:0]   rot_field;

  shop_decode #(.AMT_W(AMT_W)) u_dec (
    .instr_i      (instr_i),
    .rs_low_i     (rs_low_i),
    .mode_i       (mode_i),
    .ctl_o        (ctl),
    .extra_cycle_o(extra_d)
  );

  shop_barrel #(.W(W), .AMT_W(AMT_W)) u_sh (
    .val_i  (rm_val_i),
    .kind_i (ctl.kind),
    .amt_i  (ctl.amount),
    .rrx_i  (ctl.rrx),
    .carry_i(carry_i),
    .res_o  (sh_res),
    .carry_o(sh_carry)
  );

  assign rot_field = instr_i[11:8];

  // dedicated rotator keeps the immediate off the register-shift path
  shop_rotr #(.W(W), .SW(SW)) u_imm_rot (
    .d_i  (W'(instr_i[IMM_W-1:0])),
    .amt_i(SW'({rot_field, 1'b0})),
    .q_o  (imm_res)
  );

  assign imm_carry = (rot_field != 4'd0) ? imm_res[W-1] : carry_i;

  always_comb begin
    unique case (ctl.form)
      FORM_ROT_IMM: begin
        op_d    = imm_res;
        carry_d = imm_carry;
      end
      FORM_RAW_OFFSET: begin
        op_d    = W'(instr_i[OFF_W-1:0]);
        carry_d = carry_i;
      end
      default: begin
        op_d    = sh_res;
        carry_d = sh_carry;
      end
    endcase
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        op_o          <= '0;
        carry_o       <= 1'b0;
        extra_cycle_o <= 1'b0;
      end else begin
        op_o          <= op_d;
        carry_o       <= carry_d;
        extra_cycle_o <= extra_d;
      end
    end
  end else begin : g_comb
    assign op_o          = op_d;
    assign carry_o       = carry_d;
    assign extra_cycle_o = extra_d;
  end
endmodule

// File: rtl/operand_shifter_chk.sv
`timescale 1ns/1ps
module operand_shifter_chk #(
  parameter int W       = 32,
  parameter int AMT_W   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [31:0]      instr_i,
  input logic [W-1:0]     rm_val_i,
  input logic [AMT_W-1:0] rs_low_i,
  input logic             carry_i,
  input logic             mode_i,
  input logic [W-1:0]     op_o,
  input logic             carry_o,
  input logic             extra_cycle_o
);
  logic [31:0]      s_ins;
  logic [W-1:0]     s_rm;
  logic [AMT_W-1:0] s_rs;
  logic             s_c, s_m, s_v;

  if (OUT_REG) begin : g_snap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s_ins <= '0; s_rm <= '0; s_rs <= '0; s_c <= 1'b0; s_m <= 1'b0; s_v <= 1'b0;
      end else begin
        s_ins <= instr_i; s_rm <= rm_val_i; s_rs <= rs_low_i;
        s_c <= carry_i; s_m <= mode_i; s_v <= 1'b1;
      end
    end
  end else begin : g_live
    assign s_ins = instr_i;
    assign s_rm  = rm_val_i;
    assign s_rs  = rs_low_i;
    assign s_c   = carry_i;
    assign s_m   = mode_i;
    assign s_v   = 1'b1;
  end

  logic imm_sh, reg_sh;
  assign imm_sh = s_v && !s_ins[25] && (s_m || !s_ins[4]) && !(s_m && !s_ins[25]);
  assign reg_sh = s_v && !s_m && !s_ins[25] && s_ins[4];

  AST_RAW_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_v && s_m && !s_ins[25]) |-> (op_o == W'(s_ins[11:0]) && carry_o == s_c)); // R8

  AST_LSL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imm_sh && s_ins[11:7] == 5'd0 && s_ins[6:5] == 2'b00) |-> (op_o == s_rm && carry_o == s_c)); // R4

  AST_RRX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_v && s_ins[25] == s_m && (s_m || !s_ins[4]) && s_ins[11:7] == 5'd0 && s_ins[6:5] == 2'b11)
    |-> (op_o == {s_c, s_rm[W-1:1]} && carry_o == s_rm[0])); // R5

  AST_LS_LSR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_v && s_m && s_ins[25] && s_ins[11:7] == 5'd0 && s_ins[6:5] == 2'b01)
    |-> (op_o == '0 && carry_o == s_rm[W-1])); // R7

  AST_EXTRA_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_v |-> (extra_cycle_o == reg_sh)); // R10

  AST_REG_AMT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sh && s_rs == '0) |-> (op_o == s_rm && carry_o == s_c)); // R11

  AST_ASR_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sh && s_ins[6:5] == 2'b10 && s_rs >= AMT_W'(W))
    |-> (op_o == {W{s_rm[W-1]}} && carry_o == s_rm[W-1])); // R12

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    (OUT_REG && !rst_ni) |-> (op_o == '0 && !carry_o && !extra_cycle_o)); // R1
endmodule

bind operand_shifter operand_shifter_chk #(.W(W), .AMT_W(AMT_W), .OUT_REG(OUT_REG)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .instr_i      (instr_i),
  .rm_val_i     (rm_val_i),
  .rs_low_i     (rs_low_i),
  .carry_i      (carry_i),
  .mode_i       (mode_i),
  .op_o         (op_o),
  .carry_o      (carry_o),
  .extra_cycle_o(extra_cycle_o)
);

// File: tb/operand_shifter_test.sv
`timescale 1ns/1ps
module operand_shifter_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr_i = '0, rm_val_i = '0;
  logic [7:0]  rs_low_i = '0;
  logic        carry_i = 1'b0, mode_i = 1'b0;
  logic [31:0] op_o;
  logic        carry_o, extra_cycle_o;

  int checks = 0, fails = 0;
  bit done = 0;

  bit          pend = 0;
  logic [31:0] e_op;
  logic        e_c, e_x;
  string       e_tag;

  always #5 clk = ~clk;

  operand_shifter uut (
    .clk_i(clk), .rst_ni(rst_ni), .instr_i(instr_i), .rm_val_i(rm_val_i),
    .rs_low_i(rs_low_i), .carry_i(carry_i), .mode_i(mode_i),
    .op_o(op_o), .carry_o(carry_o), .extra_cycle_o(extra_cycle_o)
  );

  localparam int K_LSL = 0, K_LSR = 1, K_ASR = 2, K_ROR = 3;

  function automatic void ref_shift(input int kind, input int amt, input logic [31:0] v,
                                    input logic cin, output logic [31:0] r, output logic co);
    logic [63:0] x;
    r = v; co = cin;
    if (amt == 0) return;
    case (kind)
      K_LSL: if (amt <= 32) begin x = {32'd0, v} << amt; r = x[31:0]; co = x[32]; end
             else begin r = '0; co = 1'b0; end
      K_LSR: if (amt <= 32) begin x = {v, 32'd0} >> amt; r = x[63:32]; co = x[31]; end
             else begin r = '0; co = 1'b0; end
      K_ASR: begin
        x = $unsigned($signed({v, 32'd0}) >>> ((amt > 32) ? 32 : amt));
        r = x[63:32]; co = x[31];
      end
      default: begin
        for (int i = 0; i < amt % 32; i++) r = {r[0], r[31:1]};
        co = r[31];
      end
    endcase
  endfunction

  function automatic void ref_model(input logic [31:0] ins, rm, input logic [7:0] rs,
                                    input logic c, m, output logic [31:0] r,
                                    output logic co, xc);
    int kind, amt;
    kind = int'(ins[6:5]);
    amt  = int'(ins[11:7]);
    xc = 1'b0;
    if (m && !ins[25]) begin
      r = {20'd0, ins[11:0]}; co = c;
    end else if (!m && ins[25]) begin
      r = {24'd0, ins[7:0]};
      for (int i = 0; i < 2 * int'(ins[11:8]); i++) r = {r[0], r[31:1]};
      co = (ins[11:8] != 0) ? r[31] : c;
    end else if (!m && ins[4]) begin
      xc = 1'b1;
      ref_shift(kind, int'(rs), rm, c, r, co);
    end else if (amt == 0 && kind == K_ROR) begin
      r = {c, rm[31:1]}; co = rm[0];
    end else if (amt == 0 && m && (kind == K_LSR || kind == K_ASR)) begin
      ref_shift(kind, 32, rm, c, r, co);
    end else begin
      ref_shift(kind, amt, rm, c, r, co);
    end
  endfunction

  task automatic check(input string tag, input logic [31:0] act, exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic settle_pending();
    if (pend) begin
      check(e_tag, op_o, e_op, "op_o");
      check(e_tag, 32'(carry_o), 32'(e_c), "carry_o");
      check(e_tag, 32'(extra_cycle_o), 32'(e_x), "extra_cycle_o");
      pend = 0;
    end
  endtask

  task automatic apply(input logic [31:0] ins, rm, input logic [7:0] rs,
                       input logic c, m, input string tag);
    @(negedge clk);
    settle_pending();
    instr_i = ins; rm_val_i = rm; rs_low_i = rs; carry_i = c; mode_i = m;
    ref_model(ins, rm, rs, c, m, e_op, e_c, e_x);
    e_tag = tag;
    pend  = 1;
  endtask

  function automatic logic [31:0] enc_imm_sh(input int amt, kind);
    return 32'hE0810003 | (32'(amt) << 7) | (32'(kind) << 5);
  endfunction
  function automatic logic [31:0] enc_reg_sh(input int kind);
    return 32'hE0810413 | (32'(kind) << 5);
  endfunction
  function automatic logic [31:0] enc_rot(input int rot, input logic [7:0] imm);
    return 32'hE2810000 | (32'(rot) << 8) | 32'(imm);
  endfunction
  function automatic logic [31:0] enc_ls_reg(input int amt, kind);
    return 32'hE7900013 | (32'(amt) << 7) | (32'(kind) << 5);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    instr_i = 32'hFFFF_FFFF; rm_val_i = 32'hDEAD_BEEF; rs_low_i = 8'hFF; carry_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", op_o, 32'd0, "op_o in reset");
    check("R1", 32'({carry_o, extra_cycle_o}), 32'd0, "flags in reset");
    rst_ni = 1'b1;

    // R2 rotated immediate
    apply(enc_rot(4, 8'hFF), 32'h0, 0, 1'b0, 1'b0, "R2 rot8");
    apply(enc_rot(0, 8'h81), 32'h0, 0, 1'b1, 1'b0, "R2 rot0 carry pass");
    apply(enc_rot(1, 8'h01), 32'h0, 0, 1'b0, 1'b0, "R2 rot2");
    // R3 immediate shifts
    apply(enc_imm_sh(4, K_LSL), 32'hF000_000F, 0, 1'b0, 1'b0, "R3 lsl4");
    apply(enc_imm_sh(1, K_LSR), 32'h8000_0001, 0, 1'b0, 1'b0, "R3 lsr1");
    apply(enc_imm_sh(31, K_ASR), 32'h8000_0000, 0, 1'b0, 1'b0, "R3 asr31");
    apply(enc_imm_sh(8, K_ROR), 32'h1234_5680, 0, 1'b0, 1'b0, "R3 ror8");
    // R4..R6 zero amounts in operand mode
    apply(enc_imm_sh(0, K_LSL), 32'hCAFE_0001, 0, 1'b1, 1'b0, "R4 lsl0");
    apply(enc_imm_sh(0, K_ROR), 32'h0000_0002, 0, 1'b1, 1'b0, "R5 rrx carry in");
    apply(enc_imm_sh(0, K_ROR), 32'h8000_0001, 0, 1'b0, 1'b0, "R5 rrx carry out");
    apply(enc_imm_sh(0, K_LSR), 32'h8000_0001, 0, 1'b1, 1'b0, "R6 lsr0");
    apply(enc_imm_sh(0, K_ASR), 32'h8000_0001, 0, 1'b0, 1'b0, "R6 asr0");
    // R7..R9 offset mode
    apply(enc_ls_reg(0, K_LSR), 32'h8000_0001, 0, 1'b0, 1'b1, "R7 lsr0 as 32");
    apply(enc_ls_reg(0, K_ASR), 32'h8000_0001, 0, 1'b0, 1'b1, "R7 asr0 as 32");
    apply(enc_ls_reg(0, K_ASR), 32'h7FFF_FFFF, 0, 1'b1, 1'b1, "R7 asr0 positive");
    apply(32'hE5901ABC | 32'h10, 32'hFFFF_FFFF, 8'h3, 1'b1, 1'b1, "R8 raw offset");
    apply(enc_ls_reg(3, K_LSL), 32'h0000_0011, 8'h1, 1'b0, 1'b1, "R9 lsl3 bit4 set");
    apply(enc_ls_reg(0, K_ROR), 32'h0000_0003, 0, 1'b1, 1'b1, "R9 R5 rrx offset");
    apply(enc_ls_reg(0, K_LSL), 32'h0000_0003, 0, 1'b1, 1'b1, "R9 R4 lsl0 offset");
    // R10..R12 register-held amount
    apply(enc_reg_sh(K_LSR), 32'hF0F0_0008, 8'd4, 1'b0, 1'b0, "R10 lsr by reg");
    for (int k = 0; k < 4; k++) apply(enc_reg_sh(k), 32'h9000_0001, 8'd0, 1'b1, 1'b0, "R11 amount 0");
    for (int k = 0; k < 4; k++) begin
      apply(enc_reg_sh(k), 32'h8000_0001, 8'd32, 1'b0, 1'b0, "R12 amount 32");
      apply(enc_reg_sh(k), 32'h8000_0001, 8'd33, 1'b1, 1'b0, "R12 amount 33");
      apply(enc_reg_sh(k), 32'h8000_0003, 8'd255, 1'b0, 1'b0, "R12 amount 255");
      apply(enc_reg_sh(k), 32'h4000_0003, 8'd64, 1'b0, 1'b0, "R12 amount 64");
      apply(enc_reg_sh(k), 32'h8765_4321, 8'd31, 1'b1, 1'b0, "R12 amount 31");
    end

    for (int i = 0; i < 5000; i++) begin
      logic [31:0] ins;
      logic [7:0]  rs;
      ins = $urandom;
      rs  = ($urandom_range(3) == 0) ? 8'($urandom) : 8'($urandom_range(40));
      apply(ins, $urandom, rs, 1'($urandom), 1'($urandom), "R2 R3 R10 random");
    end

    @(negedge clk);
    settle_pending();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule